// File: doc/BRIEF.md
# Double-Buffered Four-Channel Motor PWM Generator

This block produces eight motor-drive PWM waveforms from one shared up-counter. A prescaler divides the system clock by a power of two and sets the counter's rate. The counter climbs to a programmable period value, returns to zero and repeats. Each of four duty channels owns two neighbouring pins. A per-channel select bit decides which pin of the pair carries that channel's pulse, and the other pin stays low.

Software writes duty values and select bits into staging registers. They take effect only at the instant the counter meets the period, so a frame is never cut short or stretched by an update made part way through it. The same event raises a sticky match flag that can drive an interrupt line. Each pin has its own enable gate and its own polarity inverter ahead of a final output register. A single-cycle write strobe and a registered read port reach all the settings and the live state.

Top module: `mpwm_timer`

## Requirements
- R1: After reset, pwm_out is 0, irq is 0, the counter reads 0 and the control register (address 0) reads 0. The period register (address 1) resets to 1023.
- R2: The counter advances only while the run bit (control bit 0) is 1. Clearing the run bit holds the counter at its value, and the read-back at address 12 stays unchanged.
- R3: The clock-select field (control bits 6:4), with value n from 0 to 7, makes the counter advance once every 2^n clocks while running.
- R4: On an advance where the counter equals the period register (address 1, bits 9:0), the counter becomes 0, and this event is called a period match. Otherwise the counter increments by one.
- R5: The staging registers (addresses 4 to 7 for channels 0 to 3; bits 9:0 hold the duty, bit 15 holds the select) are copied into the active registers (read back at addresses 8 to 11 in the same layout) on a period match and at no other time.
- R6: On a period match, channel c drives pin 2c high if its new select bit is 0, or pin 2c+1 high if it is 1. The other pin of the pair is driven low and stays low.
- R7: On a non-match advance where the counter equals a channel's active duty, that channel's pin goes low. The pulse therefore lasts duty+1 counter steps, and a duty above the period keeps the pin high.
- R8: A period match sets the flag (control bit 2). A control write with bit 2 at 0 clears the flag, and a write with bit 2 at 1 leaves it as it is. A match in the same cycle as a clearing write leaves the flag set.
- R9: irq equals the match flag ANDed with the interrupt-enable bit (control bit 1), both taken one clock earlier.
- R10: Pin i is forced low when its enable bit (address 3, bit i) is 0. It is then inverted when its polarity bit (address 2, bit i) is 1. pwm_out is registered one clock behind the pulse state.
- R11: reg_rdata presents, one clock later, the register selected by reg_addr. The counter is at address 12, and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Register address for the write and the read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pwm_out | output | 8 | PWM pins; channel c drives bits 2c and 2c+1 |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench aims at a duty of zero, which must still give a one-step pulse, and at a duty above the period, which must hold the pin high. A design that compared with the wrong bound would drop these pulses or leave them on. It writes staging values and changes the select bit while a frame is running: an early transfer shows up as a changed active read-back or as a pin flipping before the frame ends, and a pair that fails to steer shows both pins high. It also covers a clearing write against a match in the same cycle, a write of 1 to the flag, and shrinking the period below the live count. A wrong flag priority would lose an interrupt, and a wrong wrap would skip or repeat a frame.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CSEL_W = 3;
  localparam int ADR_W  = 4;

  localparam logic [ADR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADR_W-1:0] A_PERIOD = 4'd1;
  localparam logic [ADR_W-1:0] A_POL    = 4'd2;
  localparam logic [ADR_W-1:0] A_EN     = 4'd3;
  localparam logic [ADR_W-1:0] A_STAGE0 = 4'd4;
  localparam logic [ADR_W-1:0] A_ACT0   = 4'd8;
  localparam logic [ADR_W-1:0] A_CNT    = 4'd12;

  localparam int B_RUN  = 0;
  localparam int B_IE   = 1;
  localparam int B_FLAG = 2;
  localparam int B_CSEL = 4;
  localparam int B_OSEL = 15;

  typedef struct packed {
    logic [CSEL_W-1:0] csel;
    logic              ie;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/mpwm_timebase.sv
module mpwm_timebase
  import mpwm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PRESC_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CSEL_W-1:0] csel,
  input  logic [CNT_W-1:0]  period,
  output logic              tick,
  output logic              match,
  output logic [CNT_W-1:0]  cnt
);
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] mask;

  always_comb begin
    mask  = PRESC_W'((32'd1 << csel) - 32'd1);
    tick  = run && ((presc & mask) == mask);
    match = tick && (cnt == period);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presc <= '0;
      cnt   <= '0;
    end else begin
      presc <= run ? presc + 1'b1 : '0;
      if (tick) begin
        if (cnt == period) cnt <= '0;
        else               cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             match,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] stage_duty,
  input  logic             stage_sel,
  output logic [CNT_W-1:0] act_duty,
  output logic             act_sel,
  output logic [1:0]       pair_raw
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_duty <= '0;
      act_sel  <= 1'b0;
      pair_raw <= 2'b00;
    end else if (match) begin
      act_duty <= stage_duty;
      act_sel  <= stage_sel;
      pair_raw <= stage_sel ? 2'b10 : 2'b01;
    end else if (tick && (cnt == act_duty)) begin
      pair_raw <= 2'b00;
    end
  end
endmodule

// File: rtl/mpwm_outstage.sv
module mpwm_outstage #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] raw,
  input  logic [NPIN-1:0] en,
  input  logic [NPIN-1:0] pol,
  output logic [NPIN-1:0] pins
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pins[i] <= 1'b0;
      else     pins[i] <= (raw[i] & en[i]) ^ pol[i];
    end
  end
endmodule

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NCH    = 4,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADR_W-1:0]           addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       match,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [NCH-1:0][CNT_W-1:0]  act_duty,
  input  logic [NCH-1:0]             act_sel,
  output ctrl_t                      ctrl,
  output logic [CNT_W-1:0]           period,
  output logic [2*NCH-1:0]           pol,
  output logic [2*NCH-1:0]           en,
  output logic [NCH-1:0][CNT_W-1:0]  stage_duty,
  output logic [NCH-1:0]             stage_sel,
  output logic                       flag,
  output logic                       irq,
  output logic [DATA_W-1:0]          rdata
);
  localparam int NPIN = 2 * NCH;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      period <= '1;
      pol    <= '0;
      en     <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          ctrl.run  <= wdata[B_RUN];
          ctrl.ie   <= wdata[B_IE];
          ctrl.csel <= wdata[B_CSEL +: CSEL_W];
        end
        A_PERIOD: period <= wdata[CNT_W-1:0];
        A_POL:    pol    <= wdata[NPIN-1:0];
        A_EN:     en     <= wdata[NPIN-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_duty[c] <= '0;
        stage_sel[c]  <= 1'b0;
      end else if (we && (addr == ADR_W'(A_STAGE0 + c))) begin
        stage_duty[c] <= wdata[CNT_W-1:0];
        stage_sel[c]  <= wdata[B_OSEL];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (match)                                         flag <= 1'b1;
      else if (we && addr == A_CTRL && !wdata[B_FLAG])   flag <= 1'b0;
      irq <= flag & ctrl.ie;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[B_RUN]               = ctrl.run;
        rd_mux[B_IE]                = ctrl.ie;
        rd_mux[B_FLAG]              = flag;
        rd_mux[B_CSEL +: CSEL_W]    = ctrl.csel;
      end
      A_PERIOD: rd_mux[CNT_W-1:0] = period;
      A_POL:    rd_mux[NPIN-1:0]  = pol;
      A_EN:     rd_mux[NPIN-1:0]  = en;
      A_CNT:    rd_mux[CNT_W-1:0] = cnt;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADR_W'(A_STAGE0 + c)) begin
        rd_mux[CNT_W-1:0] = stage_duty[c];
        rd_mux[B_OSEL]    = stage_sel[c];
      end
      if (addr == ADR_W'(A_ACT0 + c)) begin
        rd_mux[CNT_W-1:0] = act_duty[c];
        rd_mux[B_OSEL]    = act_sel[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/mpwm_timer.sv
module mpwm_timer
  import mpwm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int NCH     = 4,
  parameter int PRESC_W = 7,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2*NCH-1:0]  pwm_out,
  output logic              irq
);
  localparam int NPIN = 2 * NCH;

  ctrl_t                     ctrl;
  logic [CNT_W-1:0]          period;
  logic [NPIN-1:0]           pol;
  logic [NPIN-1:0]           en;
  logic [NCH-1:0][CNT_W-1:0] stage_duty;
  logic [NCH-1:0]            stage_sel;
  logic [NCH-1:0][CNT_W-1:0] act_duty;
  logic [NCH-1:0]            act_sel;
  logic                      flag;
  logic                      tick;
  logic                      match;
  logic [CNT_W-1:0]          cnt;
  logic [NPIN-1:0]           raw;

  mpwm_regs #(.CNT_W(CNT_W), .NCH(NCH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .match(match), .cnt(cnt), .act_duty(act_duty), .act_sel(act_sel),
    .ctrl(ctrl), .period(period), .pol(pol), .en(en),
    .stage_duty(stage_duty), .stage_sel(stage_sel),
    .flag(flag), .irq(irq), .rdata(reg_rdata)
  );

  mpwm_timebase #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_tb (
    .clk(clk), .rst(rst), .run(ctrl.run), .csel(ctrl.csel), .period(period),
    .tick(tick), .match(match), .cnt(cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .match(match), .cnt(cnt),
      .stage_duty(stage_duty[c]), .stage_sel(stage_sel[c]),
      .act_duty(act_duty[c]), .act_sel(act_sel[c]),
      .pair_raw(raw[2*c+1:2*c])
    );
  end

  mpwm_outstage #(.NPIN(NPIN)) u_out (
    .clk(clk), .rst(rst), .raw(raw), .en(en), .pol(pol), .pins(pwm_out)
  );
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk #(
  parameter int CNT_W = 10,
  parameter int NCH   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      run,
  input logic                      tick,
  input logic                      match,
  input logic [CNT_W-1:0]          cnt,
  input logic [CNT_W-1:0]          period,
  input logic                      flag,
  input logic                      ie,
  input logic                      irq,
  input logic [2*NCH-1:0]          raw,
  input logic [2*NCH-1:0]          en,
  input logic [2*NCH-1:0]          pol,
  input logic [2*NCH-1:0]          pwm_out,
  input logic [NCH-1:0][CNT_W-1:0] act_duty
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == period) |=> (cnt == '0)); // R4

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
    !match |=> $stable(act_duty)); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_pair
    AST_PAIR_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(raw[2*c+1:2*c])); // R6
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    match |=> flag); // R8

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(flag && ie))); // R9

  AST_GATE_POL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pwm_out & ~$past(en)) == ($past(pol) & ~$past(en)))); // R10
endmodule

bind mpwm_timer mpwm_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl.run), .tick(tick), .match(match),
  .cnt(cnt), .period(period), .flag(flag), .ie(ctrl.ie), .irq(irq),
  .raw(raw), .en(en), .pol(pol), .pwm_out(pwm_out), .act_duty(act_duty)
);

// File: tb/mpwm_timer_tb.sv
module mpwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pwm_out;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  mpwm_timer u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  // Reference state built from the requirements
  logic       m_run, m_ie, m_flag;
  logic [2:0] m_csel;
  logic [9:0] m_period, m_cnt;
  logic [6:0] m_presc;
  logic [7:0] m_pol, m_en, m_raw, m_pin;
  logic [9:0] m_stage [4];
  logic       m_ssel  [4];
  logic [9:0] m_act   [4];
  logic       m_asel  [4];
  logic       m_irq;
  logic [15:0] m_rd;
  logic [3:0]  m_rd_addr;

  function automatic logic [15:0] model_read(input logic [3:0] a);
    logic [15:0] v;
    v = '0;
    case (a)
      4'd0: v = {9'd0, m_csel, 1'b0, m_flag, m_ie, m_run};
      4'd1: v = {6'd0, m_period};
      4'd2: v = {8'd0, m_pol};
      4'd3: v = {8'd0, m_en};
      4'd4, 4'd5, 4'd6, 4'd7: v = {m_ssel[a-4], 5'd0, m_stage[a-4]};
      4'd8, 4'd9, 4'd10, 4'd11: v = {m_asel[a-8], 5'd0, m_act[a-8]};
      4'd12: v = {6'd0, m_cnt};
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ie = 0; m_flag = 0; m_csel = 0; m_period = 10'h3FF;
      m_cnt = 0; m_presc = 0; m_pol = 0; m_en = 0; m_raw = 0; m_pin = 0;
      m_irq = 0; m_rd = 0; m_rd_addr = 0;
      for (int c = 0; c < 4; c++) begin
        m_stage[c] = 0; m_ssel[c] = 0; m_act[c] = 0; m_asel[c] = 0;
      end
    end else begin
      logic [6:0] mask;
      logic tk, mt;
      m_rd = model_read(reg_addr);
      m_rd_addr = reg_addr;
      m_pin = (m_raw & m_en) ^ m_pol;
      m_irq = m_flag & m_ie;
      mask = 7'((32'd1 << m_csel) - 1);
      tk = m_run && ((m_presc & mask) == mask);
      mt = tk && (m_cnt == m_period);
      for (int c = 0; c < 4; c++) begin
        if (mt) begin
          m_act[c] = m_stage[c];
          m_asel[c] = m_ssel[c];
          m_raw[2*c]   = !m_ssel[c];
          m_raw[2*c+1] = m_ssel[c];
        end else if (tk && m_cnt == m_act[c]) begin
          m_raw[2*c] = 0;
          m_raw[2*c+1] = 0;
        end
      end
      if (tk) m_cnt = mt ? 10'd0 : m_cnt + 10'd1;
      m_presc = m_run ? m_presc + 7'd1 : 7'd0;
      if (mt) m_flag = 1;
      else if (reg_we && reg_addr == 0 && !reg_wdata[2]) m_flag = 0;
      if (reg_we) begin
        case (reg_addr)
          4'd0: begin m_run = reg_wdata[0]; m_ie = reg_wdata[1]; m_csel = reg_wdata[6:4]; end
          4'd1: m_period = reg_wdata[9:0];
          4'd2: m_pol = reg_wdata[7:0];
          4'd3: m_en = reg_wdata[7:0];
          4'd4, 4'd5, 4'd6, 4'd7: begin
            m_stage[reg_addr-4] = reg_wdata[9:0];
            m_ssel[reg_addr-4]  = reg_wdata[15];
          end
          default: ;
        endcase
      end
    end
  end

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R8 R11 ctrl";
      4'd12: return "R2 R3 R4 count";
      4'd8, 4'd9, 4'd10, 4'd11: return "R5 active";
      default: return "R11 readback";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && model_on) begin
      check("R6 R7 R10 pins", {24'd0, pwm_out}, {24'd0, m_pin});
      check("R9 irq", {31'd0, irq}, {31'd0, m_irq});
      check(tag_of(m_rd_addr), {16'd0, reg_rdata}, {16'd0, m_rd});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    int hi, lo;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    model_on = 1;
    // R1
    check("R1 pins", {24'd0, pwm_out}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd12, a); check("R1 count", {16'd0, a}, 32'd0);
    rd(4'd0, a);  check("R1 ctrl", {16'd0, a}, 32'd0);
    rd(4'd1, a);  check("R1 period", {16'd0, a}, 32'h3FF);

    wr(4'd1, 16'd9);
    wr(4'd3, 16'h00FF);
    wr(4'd4, 16'h0003);
    wr(4'd5, 16'h8005);
    wr(4'd6, 16'h0000);
    wr(4'd7, 16'h800C);
    rd(4'd8, a); check("R5 no transfer before match", {16'd0, a}, 32'd0);
    wr(4'd0, 16'h0003);
    repeat (30) @(negedge clk);
    rd(4'd8, a); check("R5 ch0 transferred", {16'd0, a}, 32'h0003);
    rd(4'd9, a); check("R5 ch1 transferred", {16'd0, a}, 32'h8005);
    rd(4'd0, a); check("R8 flag set", {31'd0, a[2]}, 32'd1);
    check("R9 irq raised", {31'd0, irq}, 32'd1);

    // R7 / R4: duty 3 on pin 0, period 9
    while (pwm_out[0] !== 1'b0) @(negedge clk);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    hi = 0; lo = 0;
    while (pwm_out[0] === 1'b1) begin hi++; @(negedge clk); end
    while (pwm_out[0] === 1'b0 && lo < 50) begin lo++; @(negedge clk); end
    check("R7 pulse width", hi, 32'd4);
    check("R4 frame length", hi + lo, 32'd10);
    check("R6 unselected pin", {31'd0, pwm_out[1]}, 32'd0);
    check("R7 duty above period", {31'd0, pwm_out[7]}, 32'd1);

    // R3: divide by 4
    wr(4'd1, 16'd1000);
    wr(4'd0, 16'h0027);
    rd(4'd12, a);
    repeat (6) @(negedge clk);
    rd(4'd12, b);
    check("R3 divide by four", {16'd0, b - a}, 32'd2);

    // R2: stop holds count
    wr(4'd0, 16'h0022);
    rd(4'd12, a);
    repeat (10) @(negedge clk);
    rd(4'd12, b);
    check("R2 hold", {16'd0, b}, {16'd0, a});

    // R8: writing 1 does not set the flag
    wr(4'd0, 16'h0006);
    rd(4'd0, a); check("R8 write one no set", {31'd0, a[2]}, 32'd0);
    @(negedge clk);
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // R10: disabled pins with inversion
    wr(4'd3, 16'h000F);
    wr(4'd2, 16'h00F0);
    @(negedge clk);
    check("R10 gated inverted", {28'd0, pwm_out[7:4]}, 32'hF);

    // Random phase
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      reg_addr = 4'($urandom % 13);
      reg_we = 0;
      if ($urandom % 6 == 0) begin
        logic [3:0] wa;
        wa = 4'($urandom % 8);
        reg_we = 1;
        reg_addr = wa;
        case (wa)
          4'd0: reg_wdata = {9'd0, ($urandom % 8 == 0) ? 3'd7 : 3'($urandom % 3), 1'b0,
                             1'($urandom), 1'($urandom), ($urandom % 6 != 0)};
          4'd1: reg_wdata = 16'(2 + $urandom % 30);
          4'd2, 4'd3: reg_wdata = 16'($urandom % 256);
          default: reg_wdata = {1'($urandom), 5'd0, 10'($urandom % 36)};
        endcase
      end
    end
    @(negedge clk);
    reg_we = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule